// File: doc/BRIEF.md
# USB Controller Interrupt Status Summary

This block forms the top-level interrupt status word of a dual-role full-speed USB controller. Its inputs are the second-level cause registers: one per host channel, one per IN endpoint and one per OUT endpoint. It also takes a port-change indication, the end-of-periodic-frame pulse and per-frame lateness information for periodic and isochronous traffic. From these it derives a small set of summary bits. The meaning of each summary bit depends on whether the controller runs as host or as device.

Software reads the summary word to find which group needs service. It then reads a flat per-unit pending vector to find the channel or endpoint, and finally reads the lower-level register. The level summaries cannot be written. They drop only after the underlying cause is cleared at its own register.

At every end of periodic frame the block samples whether scheduled work was left unfinished. It latches that fact in sticky bits that software clears by writing one. A single interrupt line is the OR of the summary word gated by a mask register.

Top module: `usb_irq_summary`

## Requirements
- R1: In host mode, status bit 25 is 1 one clock after any host channel cause field is non-zero, and 0 one clock after all are zero.
- R2: In host mode, status bit 24 follows the port-change input with one clock of delay.
- R3: In device mode, status bit 19 is 1 one clock after any OUT endpoint cause is non-zero, and bit 18 is 1 one clock after any IN endpoint cause is non-zero.
- R4: Status bits 23:22, 17:16 and every bit not named in these requirements read 0. Bits 25 and 24 read 0 in device mode, and bits 19 and 18 read 0 in host mode.
- R5: In host mode, status bit 21 is set in the clock after an end-of-frame pulse that arrives while the periodic-pending input is 1. Without a pulse it does not change.
- R6: In device mode, an end-of-frame pulse sets bit 21 if any isochronous OUT late flag is 1, and sets bit 20 if any isochronous IN late flag is 1. Bit 20 is held at 0 while in host mode.
- R7: Status bit 15 is set by every end-of-frame pulse, in the same clock in which bits 21 and 20 become set.
- R8: A write to address 0 clears bits 21, 20 and 15 where the written data holds 1. A set from an end-of-frame pulse in the same clock wins over the clear. Written data has no effect on any other status bit.
- R9: A write to address 1 loads the 32-bit mask register, which reads back at address 1. The irq output is 1 exactly when some status bit and the same mask bit are both 1.
- R10: Address 2 reads the pending vector, registered one clock after its sources. In host mode, bit i is 1 when the cause of channel i is non-zero. In device mode, bit i (i < endpoints) reflects IN endpoint i and bit 16+i reflects OUT endpoint i. All other bits are 0. Address 3 reads 0.
- R11: While reset is asserted, the status, mask and vector registers are zero and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| ch_cause | input | NUM_CH*CAUSE_W | Host channel cause registers, channel i at bits [i*CAUSE_W +: CAUSE_W] |
| port_evt | input | 1 | Port status change pending |
| in_ep_cause | input | NUM_EP*CAUSE_W | IN endpoint cause registers |
| out_ep_cause | input | NUM_EP*CAUSE_W | OUT endpoint cause registers |
| eof_pulse | input | 1 | End-of-periodic-frame pulse, one clock |
| per_pend | input | 1 | Host: periodic work for this frame still pending |
| iso_in_late | input | NUM_EP | Device: isochronous IN endpoint unfinished this frame |
| iso_out_late | input | NUM_EP | Device: isochronous OUT endpoint unfinished this frame |
| addr | input | 2 | Register address: 0 status, 1 mask, 2 pending vector, 3 none |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq | output | 1 | Masked combined interrupt |

## Verification
Several corner cases are targeted. One is a mode switch while lower-level causes stay set: a design that did not gate by role would leave host summaries visible in device mode. Another is lateness inputs raised without a frame-end pulse: a design that latched on level would set bit 21 early. A third is a write-one-clear in the same clock as a new frame end: a design giving clear priority would lose an event. The bench also writes ones to level summary bits, which a writable design would drop, and checks the IN/OUT split of the pending vector, whose halves a wrong design would swap.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int STAT_W = 32;
  localparam int B_HCH  = 25;
  localparam int B_PORT = 24;
  localparam int B_LATE = 21;
  localparam int B_ISOI = 20;
  localparam int B_OEP  = 19;
  localparam int B_IEP  = 18;
  localparam int B_EOF  = 15;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_VEC  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usb_irq_reduce.sv
module usb_irq_reduce #(
  parameter int UNITS = 4,
  parameter int CW    = 8
) (
  input  logic [UNITS*CW-1:0] cause,
  output logic [UNITS-1:0]    pend,
  output logic                any
);
  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign pend[u] = |cause[u*CW +: CW];
  end
  assign any = |pend;
endmodule

// File: rtl/usb_irq_frame.sv
module usb_irq_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic host_mode,
  input  logic eof_pulse,
  input  logic per_pend,
  input  logic iso_out_any,
  input  logic iso_in_any,
  input  logic clr_late,
  input  logic clr_isoi,
  input  logic clr_eof,
  output logic late_q,
  output logic isoi_q,
  output logic eof_q
);
  logic late_d, isoi_d, eof_d;
  logic late_hit, isoi_hit;

  always_comb begin
    late_hit = eof_pulse & (host_mode ? per_pend : iso_out_any);
    isoi_hit = eof_pulse & ~host_mode & iso_in_any;

    late_d = late_q;
    if (late_hit)      late_d = 1'b1;
    else if (clr_late) late_d = 1'b0;

    isoi_d = isoi_q;
    if (host_mode)     isoi_d = 1'b0;
    else if (isoi_hit) isoi_d = 1'b1;
    else if (clr_isoi) isoi_d = 1'b0;

    eof_d = eof_q;
    if (eof_pulse)     eof_d = 1'b1;
    else if (clr_eof)  eof_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_q <= 1'b0;
      isoi_q <= 1'b0;
      eof_q  <= 1'b0;
    end else begin
      late_q <= late_d;
      isoi_q <= isoi_d;
      eof_q  <= eof_d;
    end
  end

  // R5
  late_needs_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> $past(eof_pulse));

  // R7
  late_with_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> eof_q);

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clr_late && !eof_pulse) |-> !late_q);

  // R6
  host_drops_isoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(host_mode) |-> !isoi_q);
endmodule

// File: rtl/usb_irq_summary.sv
module usb_irq_summary
  import usb_irq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_EP   = 4,
  parameter int CAUSE_W  = 8,
  parameter int VEC_HALF = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_mode,
  input  logic [NUM_CH*CAUSE_W-1:0] ch_cause,
  input  logic                      port_evt,
  input  logic [NUM_EP*CAUSE_W-1:0] in_ep_cause,
  input  logic [NUM_EP*CAUSE_W-1:0] out_ep_cause,
  input  logic                      eof_pulse,
  input  logic                      per_pend,
  input  logic [NUM_EP-1:0]         iso_in_late,
  input  logic [NUM_EP-1:0]         iso_out_late,
  input  logic [1:0]                addr,
  input  logic                      wr_en,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic                      irq
);
  localparam int VEC_W = 2 * VEC_HALF;

  logic [NUM_CH-1:0] ch_pend;
  logic [NUM_EP-1:0] in_pend, out_pend;
  logic ch_any, in_any, out_any;

  usb_irq_reduce #(.UNITS(NUM_CH), .CW(CAUSE_W)) i_ch_red (
    .cause(ch_cause), .pend(ch_pend), .any(ch_any));
  usb_irq_reduce #(.UNITS(NUM_EP), .CW(CAUSE_W)) i_in_red (
    .cause(in_ep_cause), .pend(in_pend), .any(in_any));
  usb_irq_reduce #(.UNITS(NUM_EP), .CW(CAUSE_W)) i_out_red (
    .cause(out_ep_cause), .pend(out_pend), .any(out_any));

  logic wr_stat, wr_mask;
  assign wr_stat = wr_en && (reg_addr_e'(addr) == A_STAT);
  assign wr_mask = wr_en && (reg_addr_e'(addr) == A_MASK);

  logic late_q, isoi_q, eof_q;

  usb_irq_frame i_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_mode  (host_mode),
    .eof_pulse  (eof_pulse),
    .per_pend   (per_pend),
    .iso_out_any(|iso_out_late),
    .iso_in_any (|iso_in_late),
    .clr_late   (wr_stat & wdata[B_LATE]),
    .clr_isoi   (wr_stat & wdata[B_ISOI]),
    .clr_eof    (wr_stat & wdata[B_EOF]),
    .late_q     (late_q),
    .isoi_q     (isoi_q),
    .eof_q      (eof_q)
  );

  // level summaries: {host channel, port, OUT ep, IN ep}
  logic [3:0] lvl_d, lvl_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic [31:0] mask_d, mask_q;

  always_comb begin
    lvl_d[3] = host_mode & ch_any;
    lvl_d[2] = host_mode & port_evt;
    lvl_d[1] = ~host_mode & out_any;
    lvl_d[0] = ~host_mode & in_any;
    mask_d   = wr_mask ? wdata : mask_q;
  end

  for (genvar i = 0; i < VEC_W; i++) begin : g_vec
    logic hbit, dbit;
    if (i < NUM_CH) begin : g_h
      assign hbit = ch_pend[i];
    end else begin : g_hz
      assign hbit = 1'b0;
    end
    if (i < NUM_EP) begin : g_in
      assign dbit = in_pend[i];
    end else if (i >= VEC_HALF && i < VEC_HALF + NUM_EP) begin : g_out
      assign dbit = out_pend[i - VEC_HALF];
    end else begin : g_dz
      assign dbit = 1'b0;
    end
    assign vec_d[i] = host_mode ? hbit : dbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      vec_q  <= '0;
      mask_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      vec_q  <= vec_d;
      mask_q <= mask_d;
    end
  end

  logic [STAT_W-1:0] stat_w;
  always_comb begin
    stat_w         = '0;
    stat_w[B_HCH]  = lvl_q[3];
    stat_w[B_PORT] = lvl_q[2];
    stat_w[B_OEP]  = lvl_q[1];
    stat_w[B_IEP]  = lvl_q[0];
    stat_w[B_LATE] = late_q;
    stat_w[B_ISOI] = isoi_q;
    stat_w[B_EOF]  = eof_q;
  end

  always_comb begin
    case (reg_addr_e'(addr))
      A_STAT:  rdata = stat_w;
      A_MASK:  rdata = mask_q;
      A_VEC:   rdata = 32'(vec_q);
      default: rdata = '0;
    endcase
  end

  assign irq = |(stat_w & mask_q);

  // R1
  hch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_w[B_HCH] == $past(host_mode && (|ch_cause))));

  // R4
  dev_hides_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!host_mode) |-> !stat_w[B_HCH] && !stat_w[B_PORT]);

  // R3
  oep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_w[B_OEP] == $past(!host_mode && (|out_ep_cause))));

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en && addr == 2'd1) |-> mask_q == $past(wdata));
endmodule

// File: tb/test_usb_irq_summary.sv
module test_usb_irq_summary;
  localparam int NCH = 8, NEP = 4, CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 1'b1;
  logic [NCH*CW-1:0] ch_cause = '0;
  logic port_evt = 1'b0;
  logic [NEP*CW-1:0] in_ep_cause = '0, out_ep_cause = '0;
  logic eof_pulse = 1'b0, per_pend = 1'b0;
  logic [NEP-1:0] iso_in_late = '0, iso_out_late = '0;
  logic [1:0] addr = 2'd0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  usb_irq_summary i_usb_irq_summary (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .ch_cause(ch_cause),
    .port_evt(port_evt), .in_ep_cause(in_ep_cause), .out_ep_cause(out_ep_cause),
    .eof_pulse(eof_pulse), .per_pend(per_pend), .iso_in_late(iso_in_late),
    .iso_out_late(iso_out_late), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_stat, m_mask, m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_vec = 0;
    end else begin
      logic [31:0] s, v;
      bit any_ch, any_in, any_out;
      any_ch = 0; any_in = 0; any_out = 0; v = 0;
      for (int k = 0; k < NCH; k++)
        if (ch_cause[k*CW +: CW] != 0) begin any_ch = 1; if (host_mode) v[k] = 1; end
      for (int k = 0; k < NEP; k++) begin
        if (in_ep_cause[k*CW +: CW] != 0) begin any_in = 1; if (!host_mode) v[k] = 1; end
        if (out_ep_cause[k*CW +: CW] != 0) begin any_out = 1; if (!host_mode) v[16+k] = 1; end
      end
      s = 0;
      s[25] = host_mode && any_ch;
      s[24] = host_mode && port_evt;
      s[19] = !host_mode && any_out;
      s[18] = !host_mode && any_in;
      s[21] = m_stat[21];
      if (wr_en && addr == 0 && wdata[21]) s[21] = 0;
      if (eof_pulse && (host_mode ? per_pend : (iso_out_late != 0))) s[21] = 1;
      s[20] = m_stat[20];
      if (wr_en && addr == 0 && wdata[20]) s[20] = 0;
      if (!host_mode && eof_pulse && iso_in_late != 0) s[20] = 1;
      if (host_mode) s[20] = 0;
      s[15] = m_stat[15];
      if (wr_en && addr == 0 && wdata[15]) s[15] = 0;
      if (eof_pulse) s[15] = 1;
      if (wr_en && addr == 1) m_mask = wdata;
      m_stat = s;
      m_vec = v;
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_mask;
      2'd2: return m_vec;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison with the reference model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      string t;
      t = (addr == 0) ? "R8 status" : (addr == 1) ? "R9 mask" : "R10 vector";
      chk(t, rdata, model_read(addr));
      chk("R9 irq", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic frame_end();
    eof_pulse = 1'b1; step(); eof_pulse = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    step(); step();
    rd(2'd0, r); chk("R11 status in reset", r, 0);
    rd(2'd1, r); chk("R11 mask in reset", r, 0);
    chk("R11 irq in reset", {31'b0, irq}, 0);
    rst_n = 1'b1; cmp_en = 1'b1;
    step();

    // R1
    ch_cause[3*CW +: CW] = 8'h04; step();
    rd(2'd0, r); chk("R1 host channel set", r, 32'h0200_0000);
    rd(2'd2, r); chk("R10 host vector", r, 32'h0000_0008);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); chk("R8 level bit not writable", r, 32'h0200_0000);
    ch_cause = '0; step();
    rd(2'd0, r); chk("R1 host channel clear", r, 0);

    // R2
    port_evt = 1'b1; step();
    rd(2'd0, r); chk("R2 port set", r, 32'h0100_0000);
    port_evt = 1'b0; step();

    // R5 no pulse, then pulse
    per_pend = 1'b1; step(); step();
    rd(2'd0, r); chk("R5 no latch without frame end", r, 0);
    frame_end();
    rd(2'd0, r); chk("R7 late and frame end together", r, 32'h0020_8000);
    per_pend = 1'b0;
    wr(2'd0, 32'h0020_0000);
    rd(2'd0, r); chk("R8 w1c late bit", r, 32'h0000_8000);

    // R4 mode switch with causes held
    ch_cause = '1; port_evt = 1'b1; host_mode = 1'b0;
    out_ep_cause[2*CW +: CW] = 8'h10; in_ep_cause[1*CW +: CW] = 8'h01; step();
    rd(2'd0, r); chk("R4 device hides host bits", r, 32'h000C_8000);
    rd(2'd2, r); chk("R10 device vector split", r, 32'h0004_0002);
    rd(2'd3, r); chk("R10 unused address", r, 0);
    ch_cause = '0; port_evt = 1'b0; out_ep_cause = '0; in_ep_cause = '0;

    // R6
    iso_in_late = 4'b0100; iso_out_late = 4'b0001; per_pend = 1'b0;
    frame_end();
    iso_in_late = '0; iso_out_late = '0;
    rd(2'd0, r); chk("R6 device iso late", r, 32'h0030_8000);
    // R8 set wins over clear
    iso_in_late = 4'b0001;
    addr = 2'd0; wdata = 32'h0030_8000; wr_en = 1'b1; eof_pulse = 1'b1;
    step(); wr_en = 1'b0; eof_pulse = 1'b0; iso_in_late = '0;
    rd(2'd0, r); chk("R8 set beats clear", r, 32'h0010_8000);

    // R9
    wr(2'd1, 32'h0010_0000);
    rd(2'd1, r); chk("R9 mask readback", r, 32'h0010_0000);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(2'd0, 32'h0010_0000);
    chk("R9 irq off", {31'b0, irq}, 0);
    host_mode = 1'b1; step();
    rd(2'd0, r); chk("R6 host forces iso in bit low", r[20], 0);
    rd(2'd0, r); chk("R4 reserved bits zero", r & 32'h00C3_0000, 0);

    // random traffic, compared every clock
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 63) == 0) host_mode = ~host_mode;
      for (int k = 0; k < NCH; k++)
        ch_cause[k*CW +: CW] = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h0;
      for (int k = 0; k < NEP; k++) begin
        in_ep_cause[k*CW +: CW]  = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h0;
        out_ep_cause[k*CW +: CW] = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h0;
      end
      port_evt = ($urandom_range(0, 3) == 0);
      per_pend = $urandom_range(0, 1);
      iso_in_late = 4'($urandom); iso_out_late = 4'($urandom);
      eof_pulse = ($urandom_range(0, 7) == 0);
      addr = 2'($urandom);
      wr_en = ($urandom_range(0, 3) == 0);
      wdata = $urandom;
      step();
    end
    wr_en = 1'b0; eof_pulse = 1'b0;
    step();
    finish_run();
  end
endmodule